// File: doc/BRIEF.md
# Seeded Pseudo-Random Word Generator Peripheral

This peripheral gives a polling CPU a batch of pseudo-random 32-bit words through a small register window. Software loads five seed words, then writes the control register with both the engine-select bit and the start bit set. Once every seed slot has been filled since reset, that write launches a short run of the internal generator. The generator fills five output words, one per clock, and then raises a completion flag in the status register.

The generator is a 32-bit xorshift state. When a run starts, it is loaded with the XOR of the five stored seeds. If that XOR is zero, a fixed non-zero constant is used instead. Seed slots stay marked as filled across runs, so a restart needs no new seeds. Three status flags belong to software, which overwrites them directly. The other status flags are driven by hardware alone.

The bus takes one request per cycle. Each request carries a select, a write enable, a 7-bit word address covering a 0x200-byte window, and 32-bit write data. A read returns its data on the clock edge after the request. The read register holds that value until the next read.

Top module: `prng_periph`

## Requirements
- R1: After reset, the control register (word 0x00) reads 0 and the status register (word 0x04) reads 0x00000001. The five output words (word 0x58 to 0x5C) read 0, and no seed slot counts as written.
- R2: The value of a read request appears on rd_data after the next rising clock edge. A read of any word outside control, status and the output words returns 0. A write to any word outside control, status and the seed words (word 0x50 to 0x54) changes no readable state.
- R3: Status bit 1 is 1 only after each of the five seed words (word 0x50 to 0x54) has been written at least once since reset. If any slot is still unwritten, the bit is 0.
- R4: A generation run starts only on a control write that carries bit 3 = 1 and bit 4 = 1 while status bit 1 is 1. Any other control write leaves the output words and status bits 5 and 2 unchanged.
- R5: After every control write, control bit 4 reads 0 and the other 31 bits read as written.
- R6: After a start write, status bit 2 (busy) reads 1 for exactly five cycles. In the following cycle busy reads 0 and status bit 5 (done) reads 1.
- R7: At the start of a run the state is loaded with the XOR of the five seeds, or with 0x6D2B79F5 if that XOR is 0. Output word k (k = 0 to 4, at word 0x58 + k) receives xorshift32 applied k+1 times to the loaded state. xorshift32 is x ^= x<<13; x ^= x>>17; x ^= x<<5.
- R8: A status write sets status bits 5, 4 and 3 to the written bits 5, 4 and 3. It leaves status bits 0, 1, 2, 6, 7 and 31:8 unaffected: bit 0 stays 1, bits 6, 7 and 31:8 stay 0, and bits 1 and 2 follow seed and run state.
- R9: Seed-written flags persist after a run. A second start with no seed writes in between repeats the same five output words.
- R10: A start write issued while a run is busy does not restart the run. Bit 4 still clears, and the running batch completes from its original state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_sel | input | 1 | Bus request valid this cycle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 7 | Word address within the 0x200-byte window |
| req_wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data, registered one cycle after the read request |

## Verification
The hardest case to reach from the ports is a start write that lands while a run is still busy, with a seed rewritten just before it. If that start were wrongly accepted, the outputs would change in a way the bench can see. The stimulus gets there with three back-to-back single-cycle writes: start, seed rewrite, start again. It then checks that the batch matches the original fold, and that a later clean start produces the new fold. Exact busy length is checked with back-to-back status reads right after the start write. The zero-fold substitution is reached with all-zero seeds. Random seed sets and random status writes cover the rest against a bench model of the xorshift sequence.

// File: rtl/prng_pkg.sv
// prng_pkg: register map, status bit positions and the xorshift step
// shared by the generator peripheral. Assumes a 32-bit data path and a
// 7-bit word address over a 0x200-byte window.
package prng_pkg;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 7;

    localparam logic [ADDR_W-1:0] WA_CTRL  = 7'h00;
    localparam logic [ADDR_W-1:0] WA_STAT  = 7'h04;
    localparam logic [ADDR_W-1:0] WA_SEED0 = 7'h50;
    localparam logic [ADDR_W-1:0] WA_OUT0  = 7'h58;

    localparam int CB_ENGINE = 3;
    localparam int CB_GO     = 4;
    localparam int SB_DONE   = 5;
    localparam int SB_MSG    = 4;
    localparam int SB_PART   = 3;

    // One xorshift32 step.
    function automatic logic [DATA_W-1:0] xs32(input logic [DATA_W-1:0] x);
        logic [DATA_W-1:0] y;
        y = x ^ (x << 13);
        y = y ^ (y >> 17);
        y = y ^ (y << 5);
        return y;
    endfunction
endpackage

// File: rtl/prng_seed_bank.sv
// prng_seed_bank: stores the seed words and one written flag per slot.
// Reports when every slot has been written and offers the XOR fold of
// all stored seeds. Assumes wr_idx is in range whenever wr_en is high.
module prng_seed_bank
    import prng_pkg::*;
#(
    parameter int NUM_SLOTS = 5,
    localparam int IW = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IW-1:0]     wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    output logic              all_set,
    output logic [DATA_W-1:0] fold
);
    logic [NUM_SLOTS-1:0]              flag_q;
    logic [NUM_SLOTS-1:0][DATA_W-1:0]  seed_q;

    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
        // Capture the seed word and mark the slot as written.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                flag_q[i] <= 1'b0;
                seed_q[i] <= '0;
            end else if (wr_en && wr_idx == IW'(i)) begin
                flag_q[i] <= 1'b1;
                seed_q[i] <= wr_data;
            end
        end
    end

    // All-slots-written indication.
    assign all_set = &flag_q;

    // XOR fold of the stored seeds.
    always_comb begin
        fold = '0;
        for (int k = 0; k < NUM_SLOTS; k++) fold = fold ^ seed_q[k];
    end

    assert_seed_done_needs_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(all_set) |-> $past(wr_en));
endmodule

// File: rtl/prng_core.sv
// prng_core: multi-cycle xorshift generator. A start while idle loads the
// state (a zero seed is replaced by ZERO_FIX). Then one output word is
// written per clock, and fin marks the last one. Starts while busy are
// ignored. Assumes ZERO_FIX is non-zero.
module prng_core
    import prng_pkg::*;
#(
    parameter int               NUM_OUT  = 5,
    parameter logic [DATA_W-1:0] ZERO_FIX = 32'h6D2B79F5,
    localparam int IW = (NUM_OUT > 1) ? $clog2(NUM_OUT) : 1
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           start,
    input  logic [DATA_W-1:0]              seed,
    output logic                           busy,
    output logic                           fin,
    output logic [NUM_OUT-1:0][DATA_W-1:0] words
);
    localparam logic [IW-1:0] LAST = IW'(NUM_OUT - 1);

    logic [DATA_W-1:0] state_q;
    logic [DATA_W-1:0] nxt;
    logic [IW-1:0]     cnt_q;

    assign nxt = xs32(state_q);
    assign fin = busy && (cnt_q == LAST);

    // Run sequencing: load, step, count, finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
            cnt_q   <= '0;
            busy    <= 1'b0;
        end else if (start && !busy) begin
            state_q <= (seed == '0) ? ZERO_FIX : seed;
            cnt_q   <= '0;
            busy    <= 1'b1;
        end else if (busy) begin
            state_q <= nxt;
            cnt_q   <= cnt_q + 1'b1;
            if (fin) busy <= 1'b0;
        end
    end

    for (genvar i = 0; i < NUM_OUT; i++) begin : g_word
        // Output word i takes the step produced in its slot of the run.
        always_ff @(posedge clk) begin
            if (!rst_n) words[i] <= '0;
            else if (busy && cnt_q == IW'(i)) words[i] <= nxt;
        end
    end

    assert_state_nonzero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> state_q != '0);
    assert_busy_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !fin) |=> busy);
    assert_busy_ends_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fin |=> !busy);
    assert_no_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !fin) |=> cnt_q == $past(cnt_q) + 1'b1);
endmodule

// File: rtl/prng_periph.sv
// prng_periph: register-mapped seeded generator. Decodes single-cycle word
// requests, keeps control and status, gates starts on seeds + engine bit
// + start bit, and returns read data one cycle after the request.
// Assumes only full 32-bit word accesses.
module prng_periph
    import prng_pkg::*;
#(
    parameter int                NUM_WORDS = 5,
    parameter logic [DATA_W-1:0] ZERO_FIX  = 32'h6D2B79F5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_sel,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [DATA_W-1:0] rd_data
);
    localparam int IW = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;
    localparam logic [ADDR_W-1:0] SEED_END = WA_SEED0 + ADDR_W'(NUM_WORDS);
    localparam logic [ADDR_W-1:0] OUT_END  = WA_OUT0 + ADDR_W'(NUM_WORDS);

    logic                             wr, rd;
    logic                             wr_ctrl, wr_stat, wr_seed, in_out;
    logic [ADDR_W-1:0]                seed_off, out_off;
    logic                             seed_all, busy, fin, start;
    logic [DATA_W-1:0]                fold, ctrl_q, status_w, rd_nxt;
    logic                             done_q, msg_q, part_q;
    logic [NUM_WORDS-1:0][DATA_W-1:0] words;

    // Address decode.
    assign wr       = req_sel && req_we;
    assign rd       = req_sel && !req_we;
    assign wr_ctrl  = wr && req_addr == WA_CTRL;
    assign wr_stat  = wr && req_addr == WA_STAT;
    assign wr_seed  = wr && req_addr >= WA_SEED0 && req_addr < SEED_END;
    assign in_out   = req_addr >= WA_OUT0 && req_addr < OUT_END;
    assign seed_off = req_addr - WA_SEED0;
    assign out_off  = req_addr - WA_OUT0;
    assign start    = wr_ctrl && req_wdata[CB_ENGINE] && req_wdata[CB_GO] && seed_all;

    prng_seed_bank #(.NUM_SLOTS(NUM_WORDS)) u_seeds (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_seed),
        .wr_idx  (seed_off[IW-1:0]),
        .wr_data (req_wdata),
        .all_set (seed_all),
        .fold    (fold)
    );

    prng_core #(.NUM_OUT(NUM_WORDS), .ZERO_FIX(ZERO_FIX)) u_core (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .seed  (fold),
        .busy  (busy),
        .fin   (fin),
        .words (words)
    );

    // Control register: keeps the written value with the start bit dropped.
    always_ff @(posedge clk) begin
        if (!rst_n) ctrl_q <= '0;
        else if (wr_ctrl) begin
            ctrl_q        <= req_wdata;
            ctrl_q[CB_GO] <= 1'b0;
        end
    end

    // Software-owned status flags; completion of a run wins on done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            msg_q  <= 1'b0;
            part_q <= 1'b0;
        end else begin
            if (fin) done_q <= 1'b1;
            else if (wr_stat) done_q <= req_wdata[SB_DONE];
            if (wr_stat) begin
                msg_q  <= req_wdata[SB_MSG];
                part_q <= req_wdata[SB_PART];
            end
        end
    end

    // Status word assembly: error and bit 6 are never raised.
    assign status_w = {24'd0, 1'b0, 1'b0, done_q, msg_q, part_q, busy, seed_all, 1'b1};

    // Read selection.
    always_comb begin
        rd_nxt = '0;
        if (req_addr == WA_CTRL)      rd_nxt = ctrl_q;
        else if (req_addr == WA_STAT) rd_nxt = status_w;
        else if (in_out)              rd_nxt = words[out_off[IW-1:0]];
    end

    // Registered read data, held between reads.
    always_ff @(posedge clk) begin
        if (!rst_n) rd_data <= '0;
        else if (rd) rd_data <= rd_nxt;
    end

    assert_go_bit_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctrl |=> !ctrl_q[CB_GO]);
    assert_start_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(wr_ctrl && req_wdata[CB_ENGINE] && req_wdata[CB_GO] && seed_all));
    assert_done_after_run_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fin |=> done_q);
    assert_status_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat && !fin) |=> (done_q == $past(req_wdata[SB_DONE]) && msg_q == $past(req_wdata[SB_MSG])));
endmodule

// File: tb/sim_prng_periph.sv
module sim_prng_periph;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_sel = 1'b0;
    logic        req_we = 1'b0;
    logic [6:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [31:0] rd_data;

    int total = 0;
    int bad = 0;
    logic [31:0] exp_w [5];
    logic [31:0] seeds [5];

    always #10 clk = ~clk;

    prng_periph u0 (
        .clk(clk), .rst_n(rst_n), .req_sel(req_sel), .req_we(req_we),
        .req_addr(req_addr), .req_wdata(req_wdata), .rd_data(rd_data)
    );

    function automatic logic [31:0] step(input logic [31:0] x);
        logic [31:0] y;
        y = x ^ (x << 13);
        y = y ^ (y >> 17);
        y = y ^ (y << 5);
        return y;
    endfunction

    task automatic model(input logic [31:0] f);
        logic [31:0] s;
        s = (f == 32'd0) ? 32'h6D2B79F5 : f;
        for (int k = 0; k < 5; k++) begin
            s = step(s);
            exp_w[k] = s;
        end
    endtask

    function automatic logic [31:0] fold_of();
        logic [31:0] f = 32'd0;
        for (int k = 0; k < 5; k++) f = f ^ seeds[k];
        return f;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
        total++;
        if (act !== expv) begin
            bad++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, expv);
        end
    endtask

    // Called at a negedge; returns at the next negedge.
    task automatic wr(input logic [6:0] a, input logic [31:0] d);
        req_sel = 1'b1; req_we = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_sel = 1'b0; req_we = 1'b0;
    endtask

    task automatic rd(input logic [6:0] a, output logic [31:0] d);
        req_sel = 1'b1; req_we = 1'b0; req_addr = a;
        @(negedge clk);
        req_sel = 1'b0;
        d = rd_data;
    endtask

    task automatic chk_rd(input string tag, input logic [6:0] a, input logic [31:0] expv);
        logic [31:0] v;
        rd(a, v);
        chk(tag, v, expv);
    endtask

    task automatic load_seeds();
        for (int k = 0; k < 5; k++) wr(7'h50 + 7'(k), seeds[k]);
    endtask

    task automatic chk_words(input string tag);
        for (int k = 0; k < 5; k++) chk_rd(tag, 7'h58 + 7'(k), exp_w[k]);
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk_rd("R1 ctrl", 7'h00, 32'h0);
        chk_rd("R1 status", 7'h04, 32'h1);
        for (int k = 0; k < 5; k++) chk_rd("R1 out", 7'h58 + 7'(k), 32'h0);

        // R2 unmapped accesses
        chk_rd("R2 unmapped read", 7'h20, 32'h0);
        wr(7'h30, 32'hDEADBEEF);
        chk_rd("R2 unmapped write", 7'h30, 32'h0);
        wr(7'h7F, 32'hFFFFFFFF);
        chk_rd("R2 status untouched", 7'h04, 32'h1);
        chk_rd("R2 seed word reads 0", 7'h50, 32'h0);

        // R4 start without seeds
        wr(7'h00, 32'h18);
        chk_rd("R4 no seeds no busy", 7'h04, 32'h1);
        chk_rd("R5 ctrl go cleared", 7'h00, 32'h08);

        // R3 partial then full seeds
        seeds[0] = 32'h12345678; seeds[1] = 32'h9ABCDEF0; seeds[2] = 32'h0F0F0F0F;
        seeds[3] = 32'hCAFEF00D; seeds[4] = 32'h00C0FFEE;
        for (int k = 0; k < 4; k++) wr(7'h50 + 7'(k), seeds[k]);
        chk_rd("R3 partial seeds", 7'h04, 32'h1);
        wr(7'h54, seeds[4]);
        chk_rd("R3 all seeds", 7'h04, 32'h3);

        // R4 missing engine or go bit
        wr(7'h00, 32'h10);
        chk_rd("R4 go only", 7'h04, 32'h3);
        wr(7'h00, 32'hFFFFFFE7);
        chk_rd("R5 ctrl other bits", 7'h00, 32'hFFFFFFE7);
        chk_rd("R4 engine missing out", 7'h58, 32'h0);

        // R6 busy length, R7 values
        wr(7'h00, 32'h18);
        for (int k = 0; k < 5; k++) chk_rd("R6 busy", 7'h04, 32'h7);
        chk_rd("R6 done", 7'h04, 32'h23);
        model(fold_of());
        chk_words("R7 words");
        chk_rd("R5 after start", 7'h00, 32'h08);

        // R8 status writes
        wr(7'h04, 32'h18);
        chk_rd("R8 msg part", 7'h04, 32'h1B);
        wr(7'h04, 32'hFFFFFFFF);
        chk_rd("R8 all ones", 7'h04, 32'h3B);
        wr(7'h04, 32'h0);
        chk_rd("R8 zeros", 7'h04, 32'h03);

        // R9 restart without new seeds
        wr(7'h00, 32'h18);
        repeat (6) @(negedge clk);
        chk_words("R9 repeat");
        chk_rd("R9 done", 7'h04, 32'h23);

        // R10 start while busy ignored
        seeds[0] = 32'h0BADC0DE;
        model(32'h12345678 ^ seeds[1] ^ seeds[2] ^ seeds[3] ^ seeds[4]);
        wr(7'h00, 32'h18);
        wr(7'h50, seeds[0]);
        wr(7'h00, 32'h18);
        repeat (6) @(negedge clk);
        chk_words("R10 ignored");
        wr(7'h00, 32'h18);
        repeat (6) @(negedge clk);
        model(fold_of());
        chk_words("R10 new fold");

        // R7 zero fold substitution
        for (int k = 0; k < 5; k++) seeds[k] = 32'h0;
        load_seeds();
        wr(7'h00, 32'h18);
        repeat (6) @(negedge clk);
        model(32'h0);
        chk_words("R7 zero fold");

        // R1 reset clears seed flags
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk_rd("R1 status after reset", 7'h04, 32'h1);
        wr(7'h00, 32'h18);
        chk_rd("R1 R4 no start after reset", 7'h04, 32'h1);
        chk_rd("R1 out after reset", 7'h5C, 32'h0);

        // Random rounds: R7 values, R8 status writes
        for (int r = 0; r < 20; r++) begin
            logic [31:0] sw;
            for (int k = 0; k < 5; k++) seeds[k] = $urandom;
            load_seeds();
            wr(7'h00, 32'h18 | ($urandom & 32'hFFFFFFE7));
            repeat (6) @(negedge clk);
            model(fold_of());
            chk_words("R7 random");
            sw = $urandom;
            wr(7'h04, sw);
            chk_rd("R8 random", 7'h04, 32'h3 | (sw & 32'h38));
        end

        summary();
        $finish;
    end
endmodule